// File: doc/BRIEF.md
# Error-to-NMI Aggregation Controller

This block collects error events from five hardware sources and turns them into one interrupt request. The sources are a parity error seen while the chip masters the low-pin-count or legacy DMA bus, a parity error seen during master cycles of the audio, disk or USB functions, a system-error indication, an I/O-check request from the serial interrupt logic, and a parity error on the upstream hub link. A software bit can also force a request. Each hardware source has its own enable bit and its own sticky status bit. A status bit is set only when its source fires while that source is enabled.

The status bits, together with the software force bit, are ORed into one request. A global enable gates that request. A routing bit then sends it either to the non-maskable interrupt output or to the system-management interrupt output, and the selected output is registered. Software reaches the block through a small register bus. Writes take effect on the clock edge. Reads are combinational. Status bits are cleared by writing ones to them. A hot-plug-unsupported control bit, when set, stops the three parity sources from having any effect. There is no streaming interface, so every pin is a plain control or status signal.

Top module: `err_nmi_agg`

## Requirements
- R1: After reset every control and status bit is 0, both request outputs are low, and reads of both registers return 0.
- R2: Control bits [4:0] enable the sources at status bits [4:0]. The order is LPC/DMA parity (0), function parity (1), system error (2), I/O check (3), hub parity (4). A status bit is set at the clock edge where its event input is high and its enable is set. An event whose enable is clear leaves the status bit at 0.
- R3: While control bit 8 (hot-plug unsupported) is 1, events on sources 0, 1 and 4 set no status bit. Sources 2 and 3 are not affected by this bit.
- R4: A write to address 1 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: If an event and a clear of the same status bit happen in the same cycle, the bit stays set.
- R6: Control bit 5 (force) raises the request with no status bit set. The request follows the force bit while the bit remains set.
- R7: Control bit 6 is the global enable. While it is 0 both outputs are low. Each output is registered: it reflects the control and status values of the previous cycle.
- R8: Control bit 7 routes the request. With the bit at 0 the request drives nmi_req, and with it at 1 the request drives smi_req. The two outputs are never high at the same time.
- R9: The active output stays high while any status bit or the force bit is set. It drops one cycle after the last of these is cleared.
- R10: Address 0 reads the control bits in [8:0], address 1 reads the status bits in [4:0], and all other addresses read 0. A write to address 0 replaces the control bits [8:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| ev_dma_par | input | 1 | Parity error during LPC or legacy DMA master cycles |
| ev_func_par | input | 1 | Parity error during audio, disk or USB master cycles |
| ev_serr | input | 1 | System-error indication |
| ev_iochk | input | 1 | I/O-check request from serial interrupt logic |
| ev_hub_par | input | 1 | Upstream hub-link parity error |
| nmi_req | output | 1 | Non-maskable interrupt request, level |
| smi_req | output | 1 | System-management interrupt request, level |

## Verification
The hardest case to reach is a clear write and an event landing on the same status bit in the same cycle, while the output must stay high through the conflict. The bench holds an event input high during the very cycle it issues the write-one-to-clear. It also mixes this with writes whose data bits are zero. A long random phase then toggles enables, the hot-plug override, the routing bit and the clears, so that status bits often clear while other bits stay set.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
  localparam int NSRC   = 5;
  localparam int CTRL_W = 9;

  // source positions in both enable and status vectors
  localparam int SRC_DMA  = 0;
  localparam int SRC_FUNC = 1;
  localparam int SRC_SERR = 2;
  localparam int SRC_IOCK = 3;
  localparam int SRC_HUB  = 4;

  // control bits above the per-source enables
  localparam int C_FORCE  = 5;
  localparam int C_GLOBAL = 6;
  localparam int C_ROUTE  = 7;
  localparam int C_HPUNS  = 8;

  // sources silenced by the hot-plug-unsupported bit
  localparam logic [NSRC-1:0] PARITY_SRCS = 5'b10011;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STS  = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/nmi_sticky_bit.sv
module nmi_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n)     sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1;
    else if (clr_i) sts_o <= 1'b0;
  end
endmodule

// File: rtl/nmi_src_bank.sv
module nmi_src_bank
  import nmi_agg_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] PAR_MASK = PARITY_SRCS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  input  logic         hp_block_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] qual;

  for (genvar g = 0; g < N; g++) begin : g_src
    if (PAR_MASK[g]) begin : g_par
      assign qual[g] = ev_i[g] & en_i[g] & ~hp_block_i;
    end else begin : g_plain
      assign qual[g] = ev_i[g] & en_i[g];
    end

    nmi_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (qual[g]),
      .clr_i (clr_i[g]),
      .sts_o (sts_o[g])
    );
  end
endmodule

// File: rtl/nmi_agg_regs.sv
module nmi_agg_regs
  import nmi_agg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   sts_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(REG_STS);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_o <= '0;
    else if (wr_i && addr_i == A_CTRL)
      ctrl_o <= wdata_i[CTRL_W-1:0];
  end

  assign clr_o = (wr_i && addr_i == A_STS) ? wdata_i[NSRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)     rdata_o[CTRL_W-1:0] = ctrl_o;
    else if (addr_i == A_STS) rdata_o[NSRC-1:0]   = sts_i;
  end
endmodule

// File: rtl/nmi_out_stage.sv
module nmi_out_stage
  import nmi_agg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] sts_i,
  input  logic            force_i,
  input  logic            global_i,
  input  logic            route_i,
  output logic            nmi_o,
  output logic            smi_o
);
  logic req;
  assign req = global_i & ((|sts_i) | force_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_o <= 1'b0;
      smi_o <= 1'b0;
    end else begin
      nmi_o <= req & ~route_i;
      smi_o <= req & route_i;
    end
  end
endmodule

// File: rtl/err_nmi_agg.sv
module err_nmi_agg
  import nmi_agg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_dma_par,
  input  logic              ev_func_par,
  input  logic              ev_serr,
  input  logic              ev_iochk,
  input  logic              ev_hub_par,
  output logic              nmi_req,
  output logic              smi_req
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NSRC-1:0]   sts_q;
  logic [NSRC-1:0]   clr_mask;
  logic [NSRC-1:0]   ev_vec;

  assign ev_vec[SRC_DMA]  = ev_dma_par;
  assign ev_vec[SRC_FUNC] = ev_func_par;
  assign ev_vec[SRC_SERR] = ev_serr;
  assign ev_vec[SRC_IOCK] = ev_iochk;
  assign ev_vec[SRC_HUB]  = ev_hub_par;

  nmi_agg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .sts_i   (sts_q),
    .ctrl_o  (ctrl_q),
    .clr_o   (clr_mask),
    .rdata_o (bus_rdata)
  );

  nmi_src_bank #(.N(NSRC), .PAR_MASK(PARITY_SRCS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev_vec),
    .en_i       (ctrl_q[NSRC-1:0]),
    .hp_block_i (ctrl_q[C_HPUNS]),
    .clr_i      (clr_mask),
    .sts_o      (sts_q)
  );

  nmi_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .sts_i    (sts_q),
    .force_i  (ctrl_q[C_FORCE]),
    .global_i (ctrl_q[C_GLOBAL]),
    .route_i  (ctrl_q[C_ROUTE]),
    .nmi_o    (nmi_req),
    .smi_o    (smi_req)
  );
endmodule

// File: rtl/nmi_agg_chk.sv
module nmi_agg_chk
  import nmi_agg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ev_dma_par,
  input logic              ev_serr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [NSRC-1:0]   sts_q,
  input logic              nmi_req,
  input logic              smi_req
);
  logic [NSRC-1:0] wr_clr;
  assign wr_clr = (bus_wr && bus_addr == ADDR_W'(REG_STS)) ? bus_wdata[NSRC-1:0] : '0;

  AST_STS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts_q) & ~$past(wr_clr)) & ~sts_q) == '0)); // R4

  AST_SERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_serr && ctrl_q[SRC_SERR]) |=> sts_q[SRC_SERR]); // R5

  AST_HP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_HPUNS] && !sts_q[SRC_DMA]) |=> !sts_q[SRC_DMA]); // R3

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_GLOBAL] |=> (!nmi_req && !smi_req)); // R7

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && smi_req)); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sts_q) && ctrl_q[C_GLOBAL] && !ctrl_q[C_ROUTE]) |=> nmi_req); // R9
endmodule

bind err_nmi_agg nmi_agg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .ev_dma_par (ev_dma_par),
  .ev_serr    (ev_serr),
  .ctrl_q     (ctrl_q),
  .sts_q      (sts_q),
  .nmi_req    (nmi_req),
  .smi_req    (smi_req)
);

// File: tb/test_err_nmi_agg.sv
module test_err_nmi_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ev_dma_par = 1'b0, ev_func_par = 1'b0, ev_serr = 1'b0;
  logic        ev_iochk = 1'b0, ev_hub_par = 1'b0;
  logic        nmi_req, smi_req;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // reference state
  logic [8:0] m_ctrl = '0;
  logic [4:0] m_sts = '0;
  logic       m_nmi = 1'b0, m_smi = 1'b0;

  always #2 clk = ~clk;

  err_nmi_agg i_err_nmi_agg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_dma_par(ev_dma_par), .ev_func_par(ev_func_par), .ev_serr(ev_serr),
    .ev_iochk(ev_iochk), .ev_hub_par(ev_hub_par),
    .nmi_req(nmi_req), .smi_req(smi_req)
  );

  always @(posedge clk) begin
    logic [4:0] ev, q, clr;
    logic       req;
    if (!rst_n) begin
      m_ctrl = '0; m_sts = '0; m_nmi = 1'b0; m_smi = 1'b0;
    end else begin
      ev = {ev_hub_par, ev_iochk, ev_serr, ev_func_par, ev_dma_par};
      q = ev & m_ctrl[4:0];
      if (m_ctrl[8]) q = q & 5'b01100;
      clr = (bus_wr && bus_addr == 2'd1) ? bus_wdata[4:0] : 5'd0;
      req = m_ctrl[6] && (m_sts != 0 || m_ctrl[5]);
      m_nmi = req && !m_ctrl[7];
      m_smi = req && m_ctrl[7];
      m_sts = (m_sts & ~clr) | q;
      if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata[8:0];
    end
  end

  task automatic cmp();
    logic [15:0] exp_rd;
    exp_rd = (bus_addr == 2'd0) ? {7'd0, m_ctrl} :
             (bus_addr == 2'd1) ? {11'd0, m_sts} : 16'd0;
    checks++;
    if (nmi_req !== m_nmi || smi_req !== m_smi || bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s: nmi/smi/rdata=%b/%b/%h expected %b/%b/%h",
               cur_req, nmi_req, smi_req, bus_rdata, m_nmi, m_smi, exp_rd);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1; cmp();
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_addr = a; #1; cmp();
  endtask

  task automatic pulse(input logic [4:0] v);
    {ev_hub_par, ev_iochk, ev_serr, ev_func_par, ev_dma_par} = v;
    cyc();
    {ev_hub_par, ev_iochk, ev_serr, ev_func_par, ev_dma_par} = 5'd0;
    cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    cyc(); rd(2'd0); rd(2'd1);
    cur_req = "R10";
    wr(2'd0, 16'h001F); rd(2'd0); rd(2'd2); rd(2'd3); rd(2'd1);
    wr(2'd1, 16'h001F); wr(2'd0, 16'h0000);
    cur_req = "R2";
    wr(2'd0, 16'h0040); pulse(5'h1F); rd(2'd1);
    wr(2'd0, 16'h0045); pulse(5'h1F); rd(2'd1); cyc();
    wr(2'd1, 16'h001F); cyc(); cyc();
    cur_req = "R3";
    wr(2'd0, 16'h015F); pulse(5'h1F); rd(2'd1);
    wr(2'd1, 16'h001F); cyc();
    cur_req = "R4";
    wr(2'd0, 16'h005F); pulse(5'h0F); rd(2'd1);
    wr(2'd1, 16'h0000); rd(2'd1);
    wr(2'd1, 16'h0004); rd(2'd1);
    cur_req = "R5";
    ev_iochk = 1'b1; wr(2'd1, 16'h0008); ev_iochk = 1'b0; rd(2'd1); cyc();
    cur_req = "R9";
    wr(2'd1, 16'h0003); cyc(); wr(2'd1, 16'h0008); cyc(); cyc();
    cur_req = "R6";
    wr(2'd0, 16'h0060); cyc(); cyc(); wr(2'd0, 16'h0040); cyc(); cyc();
    cur_req = "R7";
    wr(2'd0, 16'h001F); pulse(5'h04); cyc(); wr(2'd0, 16'h005F); cyc(); cyc();
    cur_req = "R8";
    wr(2'd0, 16'h00DF); cyc(); cyc(); wr(2'd0, 16'h005F); cyc();
    wr(2'd1, 16'h001F); cyc(); cyc();
    cur_req = "R2 R3 R4 R5 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      {ev_hub_par, ev_iochk, ev_serr, ev_func_par, ev_dma_par} =
        (r[2:0] == 3'd0) ? r[12:8] & 5'(r[20:16]) : 5'd0;
      bus_wr = (r[5:3] < 3'd3);
      bus_addr = (r[7:6] == 2'd3) ? 2'd1 : r[7:6];
      bus_wdata = {7'd0, r[31:23]};
      if (bus_addr == 2'd0) bus_wdata[8] = r[31] & r[30];
      cyc();
    end
    bus_wr = 1'b0;
    {ev_hub_par, ev_iochk, ev_serr, ev_func_par, ev_dma_par} = 5'd0;
    cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule